// File: doc/BRIEF.md
# Banked SRAM Write-Protect Glue

This block is the glue between a cartridge port and one 32K asynchronous SRAM. Four active-low 8K block selects share the SRAM. The block turns them into a chip select and two upper address bits. It gates output enable and write enable with the CPU read/write strobes and the bus clock phase.

A protection input can lock one chosen block or every block. A locked write is swallowed, and the SRAM never drives the data bus during that write. Output enable is gated with the early read/write strobe, which is valid from phase 1. In a write cycle the SRAM outputs therefore stay off, whether or not the write is blocked. A second mode also holds chip select inactive for a protected write.

A registered monitor reports which side owns the data bus on each clock. It reports a clash when the SRAM drives during a write.

Top module: `wp_sram_glue`

## Requirements
- R1: With exactly one select low, `sram_cs_n` is low. `sram_addr[14:13]` holds the index of the active select: `blk_sel_n[0]` gives 00, `[1]` gives 01, `[2]` gives 10 and `[3]` (block 5) gives 11. `sram_addr[12:0]` equals `addr_lo`.
- R2: In a read (`rw_early`=1) to a selected block, `sram_oe_n` is low and `sram_we_n` is high, regardless of `phi2`.
- R3: While `rw_early`=0, `sram_oe_n` is high, for protected and unprotected blocks alike.
- R4: `sram_we_n` is low only when all of these hold: `phi2`=1, `rw_early`=0, `rw_late`=0, exactly one select is low, and that block is unprotected.
- R5: The protected set depends on the mode inputs. With `wp_en`=0 no block is protected. With `wp_en`=1 and `wp_all`=0 only `blk_sel_n[3]` is protected. With `wp_en`=1 and `wp_all`=1 every block is protected.
- R6: With `cs_gate`=1, a write to a protected block holds `sram_cs_n` high. With `cs_gate`=0 the same write keeps `sram_cs_n` low, with `sram_oe_n` and `sram_we_n` both high.
- R7: With no select low, or with two or more selects low, `sram_cs_n`, `sram_oe_n` and `sram_we_n` are all high.
- R8: One clock after each rising `clk` edge, `bus_owner` reports the state sampled at that edge. The codes are:
  - 0: idle.
  - 1: SRAM driving (`sram_cs_n` and `sram_oe_n` low).
  - 2: CPU driving (`rw_early`=0 and `phi2`=1, with the SRAM not driving).
  - 3: both driving.

  `bus_owner` is 0 after reset.
- R9: A write to a protected block leaves the stored byte unchanged. A write to an unprotected block replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor sampling clock |
| rst_n | input | 1 | Active-low reset of the monitor |
| blk_sel_n | input | 4 | Active-low 8K block selects (bit 3 is block 5) |
| addr_lo | input | 13 | CPU address bits within the block |
| rw_early | input | 1 | Early read/write strobe, 1 = read, valid in phase 1 |
| rw_late | input | 1 | Late read/write strobe, goes low late in phase 2 |
| phi2 | input | 1 | Bus clock phase 2 |
| wp_en | input | 1 | Write protection enable |
| wp_all | input | 1 | 1: protect all blocks, 0: only block 5 |
| cs_gate | input | 1 | 1: drop chip select on protected writes |
| sram_addr | output | 15 | SRAM address |
| sram_cs_n | output | 1 | SRAM chip select, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| bus_owner | output | 2 | Registered data-bus owner code |

## Verification
The hardest case to reach is a protected write, in which all write strobes arrive in their normal order but the SRAM must neither store the byte nor drive the bus. The bench runs complete bus cycles into a byte-wide SRAM model with a shared data bus. Phase 1 carries the early strobe, phase 2 rises, and the late strobe falls inside phase 2. The bench seeds the protected location, repeats the write under each protection mode and under both chip-select modes, and then reads the location back. The owner code is checked in the same cycles, so a brief drive by the SRAM during a write also shows up.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
    typedef enum logic [1:0] {
        OWN_IDLE  = 2'd0,
        OWN_SRAM  = 2'd1,
        OWN_CPU   = 2'd2,
        OWN_CLASH = 2'd3
    } owner_e;

    // internal strobes, active high
    typedef struct packed {
        logic cs;
        logic oe;
        logic we;
    } strobe_t;
endpackage

// File: rtl/wpg_blk_decode.sv
module wpg_blk_decode #(
    parameter int NBLK  = 4,
    parameter int SEL_W = $clog2(NBLK)
) (
    input  logic [NBLK-1:0]  blk_sel_n,
    output logic             single,
    output logic [SEL_W-1:0] idx
);
    logic [SEL_W:0] cnt;

    always_comb begin
        cnt = '0;
        idx = '0;
        for (int i = 0; i < NBLK; i++) begin
            if (!blk_sel_n[i]) begin
                cnt = cnt + {{SEL_W{1'b0}}, 1'b1};
                idx = SEL_W'(i);
            end
        end
        single = (cnt == {{SEL_W{1'b0}}, 1'b1});
        if (!single) idx = '0;
    end
endmodule

// File: rtl/wpg_gate.sv
module wpg_gate
    import wpg_pkg::*;
#(
    parameter int NBLK     = 4,
    parameter int SEL_W    = $clog2(NBLK),
    parameter int LOCK_IDX = NBLK - 1
) (
    input  logic             single,
    input  logic [SEL_W-1:0] idx,
    input  logic             rw_early,
    input  logic             rw_late,
    input  logic             phi2,
    input  logic             wp_en,
    input  logic             wp_all,
    input  logic             cs_gate,
    output strobe_t          stb
);
    logic [NBLK-1:0] lock_mask;
    logic            locked;
    logic            is_wr;

    for (genvar g = 0; g < NBLK; g++) begin : g_mask
        if (g == LOCK_IDX) begin : g_sel
            assign lock_mask[g] = wp_en;
        end else begin : g_oth
            assign lock_mask[g] = wp_en & wp_all;
        end
    end

    always_comb begin
        locked = single & lock_mask[idx];
        is_wr  = ~rw_early;
        stb.cs = single & ~(cs_gate & locked & is_wr);
        stb.oe = stb.cs & rw_early;
        stb.we = stb.cs & is_wr & ~rw_late & phi2 & ~locked;
    end
endmodule

// File: rtl/wpg_bus_mon.sv
module wpg_bus_mon
    import wpg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sram_drv,
    input  logic   rw_early,
    input  logic   phi2,
    output owner_e owner
);
    typedef struct packed {
        owner_e own;
    } mon_t;

    mon_t st_d, st_q;
    logic cpu_drv;

    always_comb begin
        cpu_drv = ~rw_early & phi2;
        st_d    = st_q;
        unique case ({cpu_drv, sram_drv})
            2'b00:   st_d.own = OWN_IDLE;
            2'b01:   st_d.own = OWN_SRAM;
            2'b10:   st_d.own = OWN_CPU;
            default: st_d.own = OWN_CLASH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{own: OWN_IDLE};
        else        st_q <= st_d;
    end

    assign owner = st_q.own;
endmodule

// File: rtl/wp_sram_glue.sv
module wp_sram_glue
    import wpg_pkg::*;
#(
    parameter int NBLK      = 4,
    parameter int ADDR_LO_W = 13,
    parameter int LOCK_IDX  = NBLK - 1,
    localparam int SEL_W    = $clog2(NBLK),
    localparam int ADDR_W   = ADDR_LO_W + SEL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NBLK-1:0]      blk_sel_n,
    input  logic [ADDR_LO_W-1:0] addr_lo,
    input  logic                 rw_early,
    input  logic                 rw_late,
    input  logic                 phi2,
    input  logic                 wp_en,
    input  logic                 wp_all,
    input  logic                 cs_gate,
    output logic [ADDR_W-1:0]    sram_addr,
    output logic                 sram_cs_n,
    output logic                 sram_oe_n,
    output logic                 sram_we_n,
    output logic [1:0]           bus_owner
);
    logic             single;
    logic [SEL_W-1:0] idx;
    strobe_t          stb;
    owner_e           owner;

    wpg_blk_decode #(.NBLK(NBLK), .SEL_W(SEL_W)) u_dec (
        .blk_sel_n (blk_sel_n),
        .single    (single),
        .idx       (idx)
    );

    wpg_gate #(.NBLK(NBLK), .SEL_W(SEL_W), .LOCK_IDX(LOCK_IDX)) u_gate (
        .single   (single),
        .idx      (idx),
        .rw_early (rw_early),
        .rw_late  (rw_late),
        .phi2     (phi2),
        .wp_en    (wp_en),
        .wp_all   (wp_all),
        .cs_gate  (cs_gate),
        .stb      (stb)
    );

    wpg_bus_mon u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .sram_drv (stb.cs & stb.oe),
        .rw_early (rw_early),
        .phi2     (phi2),
        .owner    (owner)
    );

    assign sram_addr = {idx, addr_lo};
    assign sram_cs_n = ~stb.cs;
    assign sram_oe_n = ~stb.oe;
    assign sram_we_n = ~stb.we;
    assign bus_owner = owner;
endmodule

// File: rtl/wpg_checker.sv
module wpg_checker #(
    parameter int NBLK     = 4,
    parameter int LOCK_IDX = NBLK - 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NBLK-1:0] blk_sel_n,
    input logic            rw_early,
    input logic            rw_late,
    input logic            phi2,
    input logic            wp_en,
    input logic            wp_all,
    input logic            cs_gate,
    input logic            sram_cs_n,
    input logic            sram_oe_n,
    input logic            sram_we_n,
    input logic [1:0]      bus_owner
);
    logic one_sel, prot;
    assign one_sel = ($countones(~blk_sel_n) == 1);
    assign prot    = one_sel && wp_en && (wp_all || !blk_sel_n[LOCK_IDX]);

    // R3
    p_oe_off_in_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rw_early |-> sram_oe_n);

    // R4
    p_we_needs_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (phi2 && !rw_early && !rw_late && one_sel && !prot));

    // R5
    p_prot_blocks_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prot |-> sram_we_n);

    // R6
    p_cs_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_gate && prot && !rw_early) |-> sram_cs_n);

    // R7
    p_multi_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~blk_sel_n) > 1) |-> (sram_cs_n && sram_oe_n && sram_we_n));

    // R8
    p_no_clash_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_cs_n && !sram_oe_n) |=> (bus_owner == 2'd1));
endmodule

bind wp_sram_glue wpg_checker #(.NBLK(NBLK), .LOCK_IDX(LOCK_IDX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .blk_sel_n (blk_sel_n),
    .rw_early  (rw_early),
    .rw_late   (rw_late),
    .phi2      (phi2),
    .wp_en     (wp_en),
    .wp_all    (wp_all),
    .cs_gate   (cs_gate),
    .sram_cs_n (sram_cs_n),
    .sram_oe_n (sram_oe_n),
    .sram_we_n (sram_we_n),
    .bus_owner (bus_owner)
);

// File: tb/wp_sram_glue_tb.sv
`timescale 1ns/1ps
module wp_sram_glue_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  blk_sel_n = 4'hF;
    logic [12:0] addr_lo = '0;
    logic        rw_early = 1'b1;
    logic        rw_late = 1'b1;
    logic        phi2 = 1'b0;
    logic        wp_en = 1'b0;
    logic        wp_all = 1'b0;
    logic        cs_gate = 1'b0;
    logic [14:0] sram_addr;
    logic        sram_cs_n, sram_oe_n, sram_we_n;
    logic [1:0]  bus_owner;

    int checks = 0;
    int fails  = 0;
    logic [7:0] cpu_data = '0;
    logic [7:0] mem [64];

    always #4 clk = ~clk;

    wp_sram_glue u_dut (
        .clk(clk), .rst_n(rst_n), .blk_sel_n(blk_sel_n), .addr_lo(addr_lo),
        .rw_early(rw_early), .rw_late(rw_late), .phi2(phi2), .wp_en(wp_en),
        .wp_all(wp_all), .cs_gate(cs_gate), .sram_addr(sram_addr),
        .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
        .bus_owner(bus_owner)
    );

    // small SRAM model: 4 blocks x 16 bytes
    function automatic int midx(logic [14:0] a);
        return int'({a[14:13], a[3:0]});
    endfunction

    always @(posedge clk)
        if (!sram_we_n && !sram_cs_n) mem[midx(sram_addr)] <= cpu_data;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobes(string req, bit cs, bit oe, bit we);
        chk(sram_cs_n == cs, {req, " cs_n"}, int'(sram_cs_n), int'(cs));
        chk(sram_oe_n == oe, {req, " oe_n"}, int'(sram_oe_n), int'(oe));
        chk(sram_we_n == we, {req, " we_n"}, int'(sram_we_n), int'(we));
    endtask

    // full write cycle; checks strobes/owner at each phase
    task automatic wr_cycle(int blk, logic [12:0] a, logic [7:0] d, bit expect_we, bit expect_cs);
        @(negedge clk);
        blk_sel_n = ~(4'b1 << blk); addr_lo = a; rw_early = 1'b0; phi2 = 1'b0; cpu_data = d;
        #1 strobes("R3 wr ph1", !expect_cs, 1'b1, 1'b1);
        @(negedge clk); phi2 = 1'b1;
        #1 chk(bus_owner == 2'd0, "R8 idle in ph1", int'(bus_owner), 0);
        strobes("R4 wr ph2 early", !expect_cs, 1'b1, 1'b1);
        @(negedge clk); rw_late = 1'b0;
        #1 chk(bus_owner == 2'd2, "R8 cpu owns", int'(bus_owner), 2);
        strobes("R4 wr strobe", !expect_cs, 1'b1, !expect_we);
        @(negedge clk); rw_late = 1'b1; phi2 = 1'b0;
        @(negedge clk); blk_sel_n = 4'hF; rw_early = 1'b1;
        #1 strobes("R7 none selected", 1'b1, 1'b1, 1'b1);
    endtask

    task automatic rd_cycle(int blk, logic [12:0] a, output logic [7:0] q);
        @(negedge clk);
        blk_sel_n = ~(4'b1 << blk); addr_lo = a; rw_early = 1'b1; phi2 = 1'b0;
        #1 strobes("R2 read ph1", 1'b0, 1'b0, 1'b1);
        chk(sram_addr == {2'(blk), a}, "R1 address", int'(sram_addr), int'({2'(blk), a}));
        @(negedge clk); phi2 = 1'b1;
        #1 chk(bus_owner == 2'd1, "R8 sram owns", int'(bus_owner), 1);
        strobes("R2 read ph2", 1'b0, 1'b0, 1'b1);
        q = mem[midx(sram_addr)];
        @(negedge clk); phi2 = 1'b0; blk_sel_n = 4'hF;
    endtask

    task automatic t_reset();
        #1 chk(bus_owner == 2'd0, "R8 reset owner", int'(bus_owner), 0);
        strobes("R7 reset idle", 1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_decode();
        for (int b = 0; b < 4; b++) begin
            @(negedge clk); blk_sel_n = ~(4'b1 << b); addr_lo = 13'h1ABC - 13'(b);
            #1 chk(sram_addr == {2'(b), 13'h1ABC - 13'(b)}, "R1 encode",
                   int'(sram_addr), int'({2'(b), 13'h1ABC - 13'(b)}));
            chk(sram_cs_n == 1'b0, "R1 cs", int'(sram_cs_n), 0);
        end
        @(negedge clk); blk_sel_n = 4'b0110;
        #1 strobes("R7 two selects", 1'b1, 1'b1, 1'b1);
        @(negedge clk); blk_sel_n = 4'b0000; rw_early = 1'b0; phi2 = 1'b1; rw_late = 1'b0;
        #1 strobes("R7 all selects write", 1'b1, 1'b1, 1'b1);
        @(negedge clk); blk_sel_n = 4'hF; rw_early = 1'b1; phi2 = 1'b0; rw_late = 1'b1;
    endtask

    task automatic t_unprot();
        logic [7:0] q;
        wp_en = 1'b0;
        for (int b = 0; b < 4; b++) begin
            wr_cycle(b, 13'h0005, 8'h30 + 8'(b), 1'b1, 1'b1);
            rd_cycle(b, 13'h0005, q);
            chk(q == 8'h30 + 8'(b), "R9 unprotected write stored", int'(q), 'h30 + b);
        end
    endtask

    task automatic t_blk5_only();
        logic [7:0] q;
        wp_en = 1'b1; wp_all = 1'b0; cs_gate = 1'b0;
        wr_cycle(3, 13'h0005, 8'hEE, 1'b0, 1'b1);
        rd_cycle(3, 13'h0005, q);
        chk(q == 8'h33, "R9 block5 kept", int'(q), 'h33);
        wr_cycle(1, 13'h0005, 8'h77, 1'b1, 1'b1);
        rd_cycle(1, 13'h0005, q);
        chk(q == 8'h77, "R5 block2 writable in single mode", int'(q), 'h77);
    endtask

    task automatic t_all();
        logic [7:0] q;
        wp_en = 1'b1; wp_all = 1'b1; cs_gate = 1'b0;
        for (int b = 0; b < 3; b++) begin
            wr_cycle(b, 13'h0005, 8'h99, 1'b0, 1'b1);
        end
        rd_cycle(0, 13'h0005, q);
        chk(q == 8'h30, "R5 all-lock kept block1", int'(q), 'h30);
        rd_cycle(2, 13'h0005, q);
        chk(q == 8'h32, "R5 all-lock kept block3", int'(q), 'h32);
    endtask

    task automatic t_csgate();
        logic [7:0] q;
        wp_en = 1'b1; wp_all = 1'b0; cs_gate = 1'b1;
        wr_cycle(3, 13'h0005, 8'h55, 1'b0, 1'b0);
        rd_cycle(3, 13'h0005, q);
        chk(q == 8'h33, "R6 gated cs keeps block5", int'(q), 'h33);
        wr_cycle(0, 13'h0005, 8'h66, 1'b1, 1'b1);
        rd_cycle(0, 13'h0005, q);
        chk(q == 8'h66, "R6 unprotected with gating", int'(q), 'h66);
        cs_gate = 1'b0;
    endtask

    task automatic t_late_gate();
        wp_en = 1'b0;
        @(negedge clk); blk_sel_n = 4'b1101; rw_early = 1'b0; phi2 = 1'b0; rw_late = 1'b0;
        #1 chk(sram_we_n == 1'b1, "R4 no we in ph1", int'(sram_we_n), 1);
        @(negedge clk); phi2 = 1'b1; rw_late = 1'b1;
        #1 chk(sram_we_n == 1'b1, "R4 no we before late strobe", int'(sram_we_n), 1);
        @(negedge clk); blk_sel_n = 4'hF; rw_early = 1'b1; phi2 = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'h00;
        mem[{2'd3, 4'd5}] = 8'h11;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_decode();
        t_unprot();
        t_blk5_only();
        t_all();
        t_csgate();
        t_late_gate();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule